// File: doc/BRIEF.md
# Audio Serial Port Frame-Clock Generator

This block produces or accepts the frame clock of an audio serial port and marks the start of each frame. All of its timing is counted in bit-clock periods. In master mode it drives the bit clock itself by toggling the pad once per core clock cycle, so one bit period is two core cycles. It also divides the bit clock into a frame clock. The frame period is programmable. The high time is either half the frame or a separate programmed count. In slave mode both clocks come from pads. They pass through a synchronizer, and the bit clock is edge-detected in the core clock domain.

Each pad has its own input and output polarity control. Frame-start detection always works on the polarity-corrected internal frame clock. A start-phase setting chooses whether a rising or a falling transition opens a frame. A small byte-wide register port holds the configuration. The 16-bit frame period cannot be written while the port is marked as powered. The period, the high time and the duty mode are copied into the generator only at a frame boundary.

Top module: `asp_fclk_gen`

## Requirements
- R1: After reset the registers read: address 0 (period low byte) 0x3F, address 1 (period high byte) 0x00, address 2 (clock config) 0x0C, address 3 (frame config) 0x08, address 4 (high-time low byte) 0x20, address 5 (high-time high byte) 0x00.
- R2: While `portPowered` is 1, writes to addresses 0 and 1 leave the period unchanged. Other registers stay writable.
- R3: In master mode (clock config bit 4 = 1) `sclkPadOut` toggles every core cycle. With period value N, the frame clock repeats every N+1 bit periods, which is 2(N+1) core cycles.
- R4: With the fixed-half bit set (frame config bit 3 = 1), the frame clock is high for floor((N+1)/2) bit periods. An odd frame puts its extra period in the low phase.
- R5: With frame config bit 3 = 0, the high time is the value H at addresses 4/5, limited to N+1 bit periods.
- R6: `frameStart` rises one bit period after the chosen transition of the polarity-corrected frame clock. That transition is falling when frame config bit 4 = 0 and rising when it is 1.
- R7: `frameStart` lasts exactly one bit period: 2 core cycles in master mode, or one slave bit-clock period.
- R8: Polarity bits in the clock config: bit 3 inverts the bit clock at the output pad, bit 2 inverts it at the input pad, bit 1 inverts the frame clock at the output pad, and bit 0 inverts it at the input pad. Output inversion does not move frame-start detection.
- R9: `sclkPadOe` and `lrckPadOe` are 1 in master mode and 0 in slave mode.
- R10: Changes to the period, high time and duty mode in master mode take effect only at a frame boundary. Every high phase matches either the old settings or the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| portPowered | input | 1 | Port powered; locks the period registers |
| sclkPadIn | input | 1 | Bit clock from pad (slave) |
| sclkPadOut | output | 1 | Bit clock to pad (master) |
| sclkPadOe | output | 1 | Bit clock pad drive enable |
| lrckPadIn | input | 1 | Frame clock from pad (slave) |
| lrckPadOut | output | 1 | Frame clock to pad (master) |
| lrckPadOe | output | 1 | Frame clock pad drive enable |
| frameStart | output | 1 | Frame-start marker, one bit period wide |

## Verification
The bench targets odd frame lengths in half-duty mode, where a generator that rounds the wrong way would put the extra bit period in the high phase. It also targets a programmed high time close to the full frame, where an off-by-one counter would shorten the low phase to zero. It inverts the frame clock at the output pad and checks frame starts against the corrected clock. A design that detected edges after the output inversion would report frames on the wrong transition there. It rewrites the period in the middle of a frame and checks that no truncated high phase appears. It also writes to the period while the port is powered, so an ignored lock shows up on readback.

// File: rtl/asp_fclk_pkg.sv
package asp_fclk_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PER_LO  = 3'd0,
    REG_PER_HI  = 3'd1,
    REG_CLK_CFG = 3'd2,
    REG_FRM_CFG = 3'd3,
    REG_HI_LO   = 3'd4,
    REG_HI_HI   = 3'd5
  } regAddr_e;

  // clock config bit positions
  localparam int CLK_MASTER_BIT   = 4;
  localparam int CLK_SCLK_OUT_INV = 3;
  localparam int CLK_SCLK_IN_INV  = 2;
  localparam int CLK_LRCK_OUT_INV = 1;
  localparam int CLK_LRCK_IN_INV  = 0;
  localparam int CLK_CFG_W        = 5;
  localparam logic [CLK_CFG_W-1:0] CLK_CFG_RST = 5'b01100;

  // frame config bit positions
  localparam int FRM_PHASE_BIT = 4;
  localparam int FRM_HALF_BIT  = 3;

  // strobes and live settings from control to datapath
  typedef struct packed {
    logic bitTick;
    logic master;
    logic fixedHalf;
    logic startPhase;
    logic lrckInInv;
    logic lrckOutInv;
  } dpCtl_t;

endpackage

// File: rtl/asp_fclk_sync.sv
module asp_fclk_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] chain;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[gi] <= RST_VAL;
        else       chain[gi] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[gi] <= RST_VAL;
        else       chain[gi] <= chain[gi-1];
      end
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/asp_fclk_ctrl.sv
module asp_fclk_ctrl
  import asp_fclk_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int PERIOD_RST  = 63,
  parameter int HIGH_RST    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              portPowered,
  input  logic              sclkPadIn,
  output logic              sclkPadOut,
  output logic              sclkPadOe,
  output logic [CNT_W-1:0]  periodVal,
  output logic [CNT_W-1:0]  highVal,
  output dpCtl_t            dpCtl
);

  localparam logic [CNT_W-1:0] PER_RST_V = CNT_W'(PERIOD_RST);
  localparam logic [CNT_W-1:0] HI_RST_V  = CNT_W'(HIGH_RST);

  logic [DATA_W-1:0]    perLo, perHi, hiLo, hiHi;
  logic [CLK_CFG_W-1:0] clkCfg;
  logic                 startPhase, fixedHalf;
  logic                 sclkGen, sclkSync, sclkInCorr, sclkInPrev;
  logic                 masterMode;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perLo      <= PER_RST_V[DATA_W-1:0];
      perHi      <= PER_RST_V[CNT_W-1:DATA_W];
      hiLo       <= HI_RST_V[DATA_W-1:0];
      hiHi       <= HI_RST_V[CNT_W-1:DATA_W];
      clkCfg     <= CLK_CFG_RST;
      startPhase <= 1'b0;
      fixedHalf  <= 1'b1;
    end else if (regWe) begin
      case (regAddr)
        REG_PER_LO:  if (!portPowered) perLo <= regWdata;
        REG_PER_HI:  if (!portPowered) perHi <= regWdata;
        REG_CLK_CFG: clkCfg <= regWdata[CLK_CFG_W-1:0];
        REG_FRM_CFG: begin
          startPhase <= regWdata[FRM_PHASE_BIT];
          fixedHalf  <= regWdata[FRM_HALF_BIT];
        end
        REG_HI_LO:   hiLo <= regWdata;
        REG_HI_HI:   hiHi <= regWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_PER_LO:  regRdata = perLo;
      REG_PER_HI:  regRdata = perHi;
      REG_CLK_CFG: regRdata[CLK_CFG_W-1:0] = clkCfg;
      REG_FRM_CFG: begin
        regRdata[FRM_PHASE_BIT] = startPhase;
        regRdata[FRM_HALF_BIT]  = fixedHalf;
      end
      REG_HI_LO:   regRdata = hiLo;
      REG_HI_HI:   regRdata = hiHi;
      default:     regRdata = '0;
    endcase
  end

  assign masterMode = clkCfg[CLK_MASTER_BIT];
  assign periodVal  = {perHi, perLo};
  assign highVal    = {hiHi, hiLo};

  // bit clock: generated in master, synchronized and edge-detected in slave
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sclkGen <= 1'b0;
    else if (!masterMode) sclkGen <= 1'b0;
    else                  sclkGen <= ~sclkGen;
  end

  asp_fclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclkSync (
    .clk (clk),
    .rstN(rstN),
    .dIn (sclkPadIn),
    .dOut(sclkSync)
  );

  assign sclkInCorr = sclkSync ^ clkCfg[CLK_SCLK_IN_INV];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkInPrev <= 1'b0;
    else       sclkInPrev <= sclkInCorr;
  end

  assign sclkPadOut = sclkGen ^ clkCfg[CLK_SCLK_OUT_INV];
  assign sclkPadOe  = masterMode;

  always_comb begin
    dpCtl.bitTick    = masterMode ? ~sclkGen : (sclkInCorr & ~sclkInPrev);
    dpCtl.master     = masterMode;
    dpCtl.fixedHalf  = fixedHalf;
    dpCtl.startPhase = startPhase;
    dpCtl.lrckInInv  = clkCfg[CLK_LRCK_IN_INV];
    dpCtl.lrckOutInv = clkCfg[CLK_LRCK_OUT_INV];
  end

  AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    portPowered |=> $stable({perHi, perLo})) else $error("period changed while powered"); // R2

  AST_MASTER_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.bitTick && dpCtl.master) |=> (!dpCtl.bitTick || !dpCtl.master)) else $error("back-to-back master ticks"); // R3

endmodule

// File: rtl/asp_fclk_dp.sv
module asp_fclk_dp
  import asp_fclk_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PERIOD_RST  = 63,
  parameter int HIGH_RST    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] highVal,
  input  logic             lrckPadIn,
  output logic             lrckPadOut,
  output logic             lrckPadOe,
  output logic             frameStart
);

  localparam int LEN_W = CNT_W + 1;

  logic [CNT_W-1:0] perSh, hiSh, cnt;
  logic             halfSh;
  logic             atWrap;
  logic [LEN_W-1:0] frameLen, highLen;
  logic             lrckGen, lrckSync, lrckInt, lrckPrev;

  assign atWrap = ctl.bitTick && (cnt == perSh);

  // frame counter and shadow settings, reloaded only at frame boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      perSh  <= CNT_W'(PERIOD_RST);
      hiSh   <= CNT_W'(HIGH_RST);
      halfSh <= 1'b1;
    end else if (!ctl.master) begin
      cnt    <= '0;
      perSh  <= periodVal;
      hiSh   <= highVal;
      halfSh <= ctl.fixedHalf;
    end else if (atWrap) begin
      cnt    <= '0;
      perSh  <= periodVal;
      hiSh   <= highVal;
      halfSh <= ctl.fixedHalf;
    end else if (ctl.bitTick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    frameLen = {1'b0, perSh} + 1'b1;
    if (halfSh)                        highLen = frameLen >> 1;
    else if ({1'b0, hiSh} > frameLen)  highLen = frameLen;
    else                               highLen = {1'b0, hiSh};
  end

  assign lrckGen = ({1'b0, cnt} < highLen);

  asp_fclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lrckSync (
    .clk (clk),
    .rstN(rstN),
    .dIn (lrckPadIn),
    .dOut(lrckSync)
  );

  assign lrckInt = ctl.master ? lrckGen : (lrckSync ^ ctl.lrckInInv);

  // frame-start edge detection on the corrected internal frame clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrckPrev   <= 1'b0;
      frameStart <= 1'b0;
    end else if (ctl.bitTick) begin
      lrckPrev   <= lrckInt;
      frameStart <= ctl.startPhase ? (lrckInt & ~lrckPrev) : (~lrckInt & lrckPrev);
    end
  end

  assign lrckPadOut = lrckGen ^ ctl.lrckOutInv;
  assign lrckPadOe  = ctl.master;

  AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= perSh) else $error("counter past frame end"); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.master && !atWrap) |=> $stable({perSh, hiSh, halfSh})) else $error("settings changed mid-frame"); // R10

  AST_FS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.bitTick |=> $stable(frameStart)) else $error("frame start changed off a bit tick"); // R7

  AST_FS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bitTick && (lrckInt == lrckPrev)) |=> !frameStart) else $error("frame start without edge"); // R6

endmodule

// File: rtl/asp_fclk_gen.sv
module asp_fclk_gen
  import asp_fclk_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PERIOD_RST  = 63,
  parameter int HIGH_RST    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              portPowered,
  input  logic              sclkPadIn,
  output logic              sclkPadOut,
  output logic              sclkPadOe,
  input  logic              lrckPadIn,
  output logic              lrckPadOut,
  output logic              lrckPadOe,
  output logic              frameStart
);

  localparam int CNT_W = 2 * DATA_W;

  dpCtl_t           dpCtl;
  logic [CNT_W-1:0] periodVal, highVal;

  asp_fclk_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST),
    .HIGH_RST(HIGH_RST), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .portPowered(portPowered),
    .sclkPadIn  (sclkPadIn),
    .sclkPadOut (sclkPadOut),
    .sclkPadOe  (sclkPadOe),
    .periodVal  (periodVal),
    .highVal    (highVal),
    .dpCtl      (dpCtl)
  );

  asp_fclk_dp #(
    .CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST),
    .HIGH_RST(HIGH_RST), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .periodVal (periodVal),
    .highVal   (highVal),
    .lrckPadIn (lrckPadIn),
    .lrckPadOut(lrckPadOut),
    .lrckPadOe (lrckPadOe),
    .frameStart(frameStart)
  );

endmodule

// File: tb/asp_fclk_gen_tb.sv
`timescale 1ns/1ps
module asp_fclk_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       portPowered = 1'b0;
  logic       sclkPadIn, sclkPadOut, sclkPadOe;
  logic       lrckPadIn, lrckPadOut, lrckPadOe, frameStart;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // slave pad stimulus: bit clock period 8 cycles, frame 32 bits
  logic [7:0] padCnt = '0;
  always @(posedge clk) padCnt <= padCnt + 8'd1;
  assign sclkPadIn = padCnt[2];
  assign lrckPadIn = padCnt[7];

  asp_fclk_gen u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .portPowered(portPowered),
    .sclkPadIn(sclkPadIn), .sclkPadOut(sclkPadOut), .sclkPadOe(sclkPadOe),
    .lrckPadIn(lrckPadIn), .lrckPadOut(lrckPadOut), .lrckPadOe(lrckPadOe),
    .frameStart(frameStart)
  );

  // bench-side view of the corrected frame clock
  bit tbMaster = 0, tbOutInv = 0, tbInInv = 0, tbPhase = 0, monOn = 0;
  logic lrckCorr;
  assign lrckCorr = tbMaster ? (lrckPadOut ^ tbOutInv) : (lrckPadIn ^ tbInInv);

  longint cyc = 0, tRise = 0, tFall = 0;
  int monFs = 0;
  logic lcPrev = 1'b0, fsPrev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (lrckCorr && !lcPrev) tRise = cyc;
    if (!lrckCorr && lcPrev) tFall = cyc;
    lcPrev = lrckCorr;
    if (frameStart && !fsPrev && monOn) begin
      monFs++;
      checks++;
      if (tbPhase ? !(tRise > tFall) : !(tFall > tRise)) begin
        errors++;
        $display("FAIL R6 frame start on wrong edge: lastRise=%0d lastFall=%0d expected phase=%0d",
                 tRise, tFall, tbPhase);
      end
    end
    fsPrev = frameStart;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk); regAddr = a; #1; v = regRdata;
  endtask

  task automatic waitFs(output bit ok);
    logic p;
    ok = 0;
    p = frameStart;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (frameStart && !p) begin ok = 1; return; end
      p = frameStart;
    end
  endtask

  task automatic measPeriod(output int n);
    bit ok;
    logic p;
    n = -1;
    waitFs(ok);
    if (!ok) return;
    n = 0;
    p = frameStart;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); n++;
      if (frameStart && !p) return;
      p = frameStart;
    end
    n = -1;
  endtask

  task automatic measFsWidth(output int n);
    bit ok;
    n = -1;
    waitFs(ok);
    if (!ok) return;
    n = 0;
    for (int k = 0; k < 4000 && frameStart; k++) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic measHigh(output int n);
    logic p;
    n = -1;
    p = lrckCorr;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (lrckCorr && !p) begin
        n = 0;
        for (int j = 0; j < 4000 && lrckCorr; j++) begin
          @(negedge clk); n++;
        end
        return;
      end
      p = lrckCorr;
    end
  endtask

  // period value, high value, fixed-half flag, expected period and high time in core cycles
  localparam int NVEC = 5;
  localparam int VEC [NVEC][5] = '{
    '{63,  0, 1, 128, 64},
    '{ 8,  0, 1,  18,  8},
    '{ 9,  3, 0,  20,  6},
    '{15, 15, 0,  32, 30},
    '{ 4,  1, 0,  10,  2}
  };

  initial begin
    int v, n;
    bit ok, sawOld;
    repeat (5) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    check("R9", {31'd0, sclkPadOe}, 0, "sclk drive after reset");
    check("R9", {31'd0, lrckPadOe}, 0, "lrck drive after reset");
    check("R1", {31'd0, frameStart}, 0, "frameStart after reset");
    rd(3'd0, v); check("R1", v, 8'h3F, "period low reset");
    rd(3'd1, v); check("R1", v, 8'h00, "period high reset");
    rd(3'd2, v); check("R1", v, 8'h0C, "clock config reset");
    rd(3'd3, v); check("R1", v, 8'h08, "frame config reset");
    rd(3'd4, v); check("R1", v, 8'h20, "high time low reset");
    rd(3'd5, v); check("R1", v, 8'h00, "high time high reset");

    // master vector table: R3 period, R4/R5 high time
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd0, 8'(VEC[i][0]));
      wr(3'd1, 8'h00);
      wr(3'd4, 8'(VEC[i][1]));
      wr(3'd5, 8'h00);
      wr(3'd3, VEC[i][2] ? 8'h08 : 8'h00);
      wr(3'd2, 8'h1C);
      tbMaster = 1; tbOutInv = 0;
      measPeriod(n);
      measPeriod(n);
      check("R3", n, VEC[i][3], $sformatf("frame period vector %0d", i));
      measHigh(n);
      check(VEC[i][2] ? "R4" : "R5", n, VEC[i][4], $sformatf("high time vector %0d", i));
    end
    check("R9", {31'd0, sclkPadOe}, 1, "sclk drive in master");
    check("R9", {31'd0, lrckPadOe}, 1, "lrck drive in master");

    // R3 bit clock toggles every cycle
    begin
      logic s0;
      @(negedge clk); s0 = sclkPadOut;
      @(negedge clk); check("R3", {31'd0, sclkPadOut}, {31'd0, ~s0}, "sclk toggle");
    end

    // R7 master frame-start width, R8 sclk output polarity
    measFsWidth(n); check("R7", n, 2, "master frameStart width");
    waitFs(ok); check("R8", {31'd0, sclkPadOut}, 0, "sclk pad at frame start, inverted");
    wr(3'd2, 8'h10);
    waitFs(ok); check("R8", {31'd0, sclkPadOut}, 1, "sclk pad at frame start, normal");

    // R8 lrck output inversion with programmed 3-of-10 high time, R6 falling start
    wr(3'd0, 8'd9); wr(3'd4, 8'd3); wr(3'd3, 8'h00);
    wr(3'd2, 8'h1A); tbOutInv = 1; tbPhase = 0;
    measPeriod(n); measPeriod(n);
    measHigh(n); check("R8", n, 6, "corrected high with output inversion");
    monFs = 0; monOn = 1;
    repeat (100) @(negedge clk);
    monOn = 0;
    checks++;
    if (monFs < 3) begin errors++; $display("FAIL R6 master falling starts: actual %0d expected >=3", monFs); end

    // R6 rising start phase in master
    wr(3'd3, 8'h10); tbPhase = 1;
    measPeriod(n); measPeriod(n);
    monFs = 0; monOn = 1;
    repeat (100) @(negedge clk);
    monOn = 0;
    checks++;
    if (monFs < 3) begin errors++; $display("FAIL R6 master rising starts: actual %0d expected >=3", monFs); end

    // R10 period change mid-frame: no partial high phase
    wr(3'd3, 8'h08); wr(3'd0, 8'd63); wr(3'd2, 8'h10); tbOutInv = 0;
    measPeriod(n); measPeriod(n);
    repeat (37) @(negedge clk);
    wr(3'd0, 8'd9);
    sawOld = 0;
    for (int k = 0; k < 4; k++) begin
      measHigh(n);
      checks++;
      if (n != 64 && n != 10) begin
        errors++;
        $display("FAIL R10 high phase %0d: actual %0d expected 64 or 10", k, n);
      end
    end
    measHigh(n); check("R10", n, 10, "new high time applied");

    // R2 period lock while powered
    portPowered = 1'b1;
    wr(3'd0, 8'h55); rd(3'd0, v); check("R2", v, 9, "period low locked");
    wr(3'd1, 8'h01); rd(3'd1, v); check("R2", v, 0, "period high locked");
    measPeriod(n); check("R2", n, 20, "period unaffected by blocked write");
    wr(3'd2, 8'h1C); rd(3'd2, v); check("R2", v, 8'h1C, "clock config writable while powered");
    portPowered = 1'b0;
    wr(3'd0, 8'h20); rd(3'd0, v); check("R2", v, 8'h20, "period writable when unpowered");

    // slave mode, falling start, no input inversion
    wr(3'd3, 8'h08); wr(3'd2, 8'h0C);
    tbMaster = 0; tbInInv = 0; tbPhase = 0;
    repeat (2) @(negedge clk);
    check("R9", {31'd0, sclkPadOe}, 0, "sclk drive in slave");
    check("R9", {31'd0, lrckPadOe}, 0, "lrck drive in slave");
    repeat (600) @(negedge clk);
    monFs = 0; monOn = 1;
    repeat (1100) @(negedge clk);
    monOn = 0;
    checks++;
    if (monFs < 3 || monFs > 5) begin errors++; $display("FAIL R6 slave starts: actual %0d expected 3..5", monFs); end
    measFsWidth(n); check("R7", n, 8, "slave frameStart width");

    // slave mode, rising start, lrck input inverted
    wr(3'd3, 8'h18); wr(3'd2, 8'h0D);
    tbInInv = 1; tbPhase = 1;
    repeat (600) @(negedge clk);
    monFs = 0; monOn = 1;
    repeat (1100) @(negedge clk);
    monOn = 0;
    checks++;
    if (monFs < 3 || monFs > 5) begin errors++; $display("FAIL R8 slave inverted starts: actual %0d expected 3..5", monFs); end
    measFsWidth(n); check("R7", n, 8, "slave frameStart width inverted");

    summary();
  end

endmodule